// File: doc/BRIEF.md
# Linked-List DMA Descriptor Loader

This block is the control half of one DMA channel. It holds a working set of registers (link, byte count, source, destination and a small configuration field) and launches a data mover with them. When the mover reports that the node is done, the loader either stops or reads the next 32-byte descriptor from memory and launches that one. Chains may end with an end marker or loop back on themselves, so that a ring of buffers keeps streaming.

Software starts a channel by writing the working registers directly and then writing the configuration word with its enable bit set. The enable bit also serves as the pause control. Clearing it while the channel is active freezes the mover in place. Setting it again lets the current node continue, and nothing is fetched again. Three single-cycle events report the channel's progress: a node finished (when that node asked for it), the chain ended, or a memory read failed.

Top module: `lli_chain_loader`

## Requirements
- R1: After reset, busy, cur_link, remain_cnt, mrd_req, mv_start and all three event outputs are 0.
- R2: A write to prog_sel 4 (config) with bit 0 set while idle starts a node from the directly written registers. prog_sel 0 is link, 1 count, 2 source and 3 destination. busy rises, and a single one-cycle mv_start carries that count, source and destination, with mv_src_inc taken from config bit 31 and mv_dst_inc from config bit 30.
- R3: A descriptor fetch issues eight word reads at base+0, +4, … +28, in ascending order, one outstanding at a time. Word 0 is the link, word 4 the count, word 5 the source, word 6 the destination and word 7 the config. Words 1 to 3 are read and discarded.
- R4: When a node completes and bit 1 of its link word is set, the next fetch starts at the link word with its low five bits cleared. Otherwise the loader raises ev_final for one cycle and busy drops in the same cycle.
- R5: A chain whose last link points back to its first descriptor runs without end, re-fetching the nodes in order and never raising ev_final.
- R6: ev_node pulses for one cycle when a node completes, if config bit 1 of that node was set. It stays low otherwise.
- R7: While busy, clearing config bit 0 holds mv_run low, with no new mv_start and no new fetch. If that node had already launched, setting the bit again resumes it without a new launch or refetch. A node fetched with bit 0 clear waits loaded and launches only when the bit is set.
- R8: A count above 0x1FFC is clamped to 0x1FFC. While busy, remain_cnt shows the current node's count in 16 bits, and it reads 0 while idle.
- R9: cur_link shows the address of the descriptor being fetched or processed, and 0 for a node started from directly written registers.
- R10: A read answered with mrd_err aborts the chain. ev_err pulses, busy drops in the same cycle, and no further launch or ev_final follows.
- R11: While busy, writes to link, count, source or destination are ignored, and so is every config bit except bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Register write strobe |
| prog_sel | input | 3 | Register select: 0 link, 1 count, 2 source, 3 destination, 4 config |
| prog_wdata | input | 32 | Register write data |
| mrd_req | output | 1 | Memory read request, held until acknowledged |
| mrd_addr | output | 32 | Memory read word address |
| mrd_ack | input | 1 | Read response valid for the current request |
| mrd_data | input | 32 | Read response data |
| mrd_err | input | 1 | Read response carries an error (valid with mrd_ack) |
| mv_start | output | 1 | One-cycle launch of the current node to the mover |
| mv_run | output | 1 | Mover may make progress (node active and enabled) |
| mv_count | output | 16 | Byte count of the current node |
| mv_src | output | 32 | Source address of the current node |
| mv_dst | output | 32 | Destination address of the current node |
| mv_src_inc | output | 1 | Source address increments |
| mv_dst_inc | output | 1 | Destination address increments |
| mv_done | input | 1 | Mover finished the launched node |
| cur_link | output | 32 | Address of the descriptor in progress |
| remain_cnt | output | 16 | Count of the current node while busy |
| busy | output | 1 | Chain active |
| ev_node | output | 1 | Per-node completion event |
| ev_final | output | 1 | Chain completion event |
| ev_err | output | 1 | Memory read error event |

## Verification
The assertions assume that the mover raises mv_done only for a node it was launched with, only while mv_run is high, and only once per launch. They also assume that mrd_err is only meaningful together with mrd_ack. The bench's mover model counts down only while mv_run is high and pulses done once per launch. Its memory model acknowledges each request in the cycle it is seen and flags an error only at one chosen address. Direct register writes are made only while the channel is idle, except for the writes that check pausing and the ignored-write rule.

// File: rtl/lli_pkg.sv
package lli_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RUN} ld_state_t;

  localparam logic [2:0] SEL_LINK  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_SRC   = 3'd2;
  localparam logic [2:0] SEL_DST   = 3'd3;
  localparam logic [2:0] SEL_CFG   = 3'd4;

  // word slots inside a descriptor
  localparam int W_LINK  = 0;
  localparam int W_COUNT = 4;
  localparam int W_SRC   = 5;
  localparam int W_DST   = 6;
  localparam int W_CFG   = 7;

  typedef struct packed {
    logic src_inc;
    logic dst_inc;
    logic node_ev;
    logic en;
  } node_cfg_t;

  function automatic node_cfg_t unpack_cfg(input logic [31:0] w);
    node_cfg_t c;
    c.src_inc = w[31];
    c.dst_inc = w[30];
    c.node_ev = w[1];
    c.en      = w[0];
    return c;
  endfunction

  function automatic logic [31:0] desc_base(input logic [31:0] link);
    return {link[31:5], 5'b0};
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] base, input int idx);
    return base + 32'(idx) * 32'd4;
  endfunction

  function automatic logic [31:0] clamp_count(input logic [31:0] raw, input logic [31:0] maxv);
    return (raw > maxv) ? maxv : raw;
  endfunction
endpackage

// File: rtl/lli_regs.sv
module lli_regs import lli_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int CNT_MAX    = 32'h1FFC,
  parameter int DESC_WORDS = 8,
  localparam int IDX_W     = $clog2(DESC_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [2:0]       prog_sel,
  input  logic [31:0]      prog_wdata,
  input  logic             busy,
  input  logic             cap_we,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [31:0]      cap_data,
  output logic [31:0]      link,
  output logic [CNT_W-1:0] count,
  output logic [31:0]      src,
  output logic [31:0]      dst,
  output node_cfg_t        cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link  <= '0;
      count <= '0;
      src   <= '0;
      dst   <= '0;
      cfg   <= '0;
    end else if (cap_we) begin
      if (cap_idx == IDX_W'(W_LINK))  link  <= cap_data;
      if (cap_idx == IDX_W'(W_COUNT)) count <= CNT_W'(clamp_count(cap_data, 32'(CNT_MAX)));
      if (cap_idx == IDX_W'(W_SRC))   src   <= cap_data;
      if (cap_idx == IDX_W'(W_DST))   dst   <= cap_data;
      if (cap_idx == IDX_W'(W_CFG))   cfg   <= unpack_cfg(cap_data);
    end else if (prog_we) begin
      if (!busy) begin
        case (prog_sel)
          SEL_LINK:  link  <= prog_wdata;
          SEL_COUNT: count <= CNT_W'(clamp_count(prog_wdata, 32'(CNT_MAX)));
          SEL_SRC:   src   <= prog_wdata;
          SEL_DST:   dst   <= prog_wdata;
          SEL_CFG:   cfg   <= unpack_cfg(prog_wdata);
          default: ;
        endcase
      end else if (prog_sel == SEL_CFG) begin
        cfg.en <= prog_wdata[0];
      end
    end
  end

  AST_CAPTURE_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && prog_we && prog_sel == SEL_COUNT && !cap_we) |=> (32'(count) <= 32'(CNT_MAX))) else $error("count above limit"); // R8
endmodule

// File: rtl/lli_fetch.sv
module lli_fetch import lli_pkg::*; #(
  parameter int DESC_WORDS = 8,
  localparam int IDX_W     = $clog2(DESC_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [31:0]      kick_base,
  output logic             mrd_req,
  output logic [31:0]      mrd_addr,
  input  logic             mrd_ack,
  input  logic [31:0]      mrd_data,
  input  logic             mrd_err,
  output logic             cap_we,
  output logic [IDX_W-1:0] cap_idx,
  output logic [31:0]      cap_data,
  output logic             fetch_last,
  output logic             fetch_err
);
  logic             active;
  logic [IDX_W-1:0] idx;
  logic [31:0]      base;

  assign mrd_req    = active;
  assign mrd_addr   = word_addr(base, int'(idx));
  assign cap_we     = active && mrd_ack && !mrd_err;
  assign cap_idx    = idx;
  assign cap_data   = mrd_data;
  assign fetch_last = cap_we && (idx == IDX_W'(DESC_WORDS - 1));
  assign fetch_err  = active && mrd_ack && mrd_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
    end else if (kick) begin
      active <= 1'b1;
      idx    <= '0;
      base   <= kick_base;
    end else if (fetch_err || fetch_last) begin
      active <= 1'b0;
    end else if (cap_we) begin
      idx <= idx + 1'b1;
    end
  end

  AST_FETCH_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_we && !fetch_last) |=> (mrd_req && mrd_addr == $past(mrd_addr) + 32'd4)) else $error("fetch order"); // R3
  AST_NO_KICK_MIDFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !mrd_req) else $error("kick while fetching"); // R4
endmodule

// File: rtl/lli_ctrl.sv
module lli_ctrl import lli_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic [31:0] link,
  input  node_cfg_t   cfg,
  input  logic        fetch_last,
  input  logic        fetch_err,
  input  logic        mv_done,
  output logic        busy,
  output logic        mv_start,
  output logic        mv_run,
  output logic        kick,
  output logic [31:0] kick_base,
  output logic [31:0] cur_link,
  output logic        ev_node,
  output logic        ev_final,
  output logic        ev_err
);
  ld_state_t state;
  logic      launched;
  logic      node_done;

  assign busy      = (state != ST_IDLE);
  assign mv_run    = (state == ST_RUN) && cfg.en;
  assign mv_start  = mv_run && !launched;
  assign node_done = mv_run && launched && mv_done;
  assign kick      = node_done && link[1];
  assign kick_base = desc_base(link);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      launched <= 1'b0;
      cur_link <= '0;
      ev_node  <= 1'b0;
      ev_final <= 1'b0;
      ev_err   <= 1'b0;
    end else begin
      ev_node  <= 1'b0;
      ev_final <= 1'b0;
      ev_err   <= 1'b0;
      case (state)
        ST_IDLE: if (start_req) begin
          state    <= ST_RUN;
          launched <= 1'b0;
          cur_link <= '0;
        end
        ST_FETCH: begin
          if (fetch_err) begin
            state  <= ST_IDLE;
            ev_err <= 1'b1;
          end else if (fetch_last) begin
            state    <= ST_RUN;
            launched <= 1'b0;
          end
        end
        ST_RUN: begin
          if (mv_start) launched <= 1'b1;
          if (node_done) begin
            ev_node <= cfg.node_ev;
            if (kick) begin
              state    <= ST_FETCH;
              cur_link <= kick_base;
            end else begin
              state    <= ST_IDLE;
              ev_final <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start) else $error("double launch"); // R2
  AST_FINAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_final |-> !busy) else $error("final while busy"); // R4
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> (!busy && !ev_final)) else $error("error did not abort"); // R10
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg.en && !fetch_last && !fetch_err && state != ST_FETCH) |=> (busy && !ev_final && !ev_node)) else $error("paused node moved"); // R7
endmodule

// File: rtl/lli_chain_loader.sv
module lli_chain_loader import lli_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int CNT_MAX    = 32'h1FFC,
  parameter int DESC_WORDS = 8,
  localparam int IDX_W     = $clog2(DESC_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [2:0]       prog_sel,
  input  logic [31:0]      prog_wdata,
  output logic             mrd_req,
  output logic [31:0]      mrd_addr,
  input  logic             mrd_ack,
  input  logic [31:0]      mrd_data,
  input  logic             mrd_err,
  output logic             mv_start,
  output logic             mv_run,
  output logic [CNT_W-1:0] mv_count,
  output logic [31:0]      mv_src,
  output logic [31:0]      mv_dst,
  output logic             mv_src_inc,
  output logic             mv_dst_inc,
  input  logic             mv_done,
  output logic [31:0]      cur_link,
  output logic [CNT_W-1:0] remain_cnt,
  output logic             busy,
  output logic             ev_node,
  output logic             ev_final,
  output logic             ev_err
);
  logic             start_req;
  logic             cap_we, fetch_last, fetch_err, kick;
  logic [IDX_W-1:0] cap_idx;
  logic [31:0]      cap_data, kick_base, link;
  logic [CNT_W-1:0] count;
  node_cfg_t        cfg;

  assign start_req = prog_we && (prog_sel == SEL_CFG) && prog_wdata[0];

  lli_regs #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .DESC_WORDS(DESC_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_sel(prog_sel), .prog_wdata(prog_wdata),
    .busy(busy), .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data),
    .link(link), .count(count), .src(mv_src), .dst(mv_dst), .cfg(cfg)
  );

  lli_fetch #(.DESC_WORDS(DESC_WORDS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_base(kick_base),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data), .mrd_err(mrd_err),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data),
    .fetch_last(fetch_last), .fetch_err(fetch_err)
  );

  lli_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .link(link), .cfg(cfg),
    .fetch_last(fetch_last), .fetch_err(fetch_err), .mv_done(mv_done),
    .busy(busy), .mv_start(mv_start), .mv_run(mv_run), .kick(kick), .kick_base(kick_base),
    .cur_link(cur_link), .ev_node(ev_node), .ev_final(ev_final), .ev_err(ev_err)
  );

  assign mv_count   = count;
  assign mv_src_inc = cfg.src_inc;
  assign mv_dst_inc = cfg.dst_inc;
  assign remain_cnt = busy ? count : '0;

  AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(remain_cnt) <= 32'(CNT_MAX))) else $error("remaining count too large"); // R8
  AST_FETCH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req |-> (mrd_addr[31:5] == cur_link[31:5])) else $error("fetch outside current node"); // R9
  AST_FETCH_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrd_req) |-> $past(mv_done)) else $error("fetch without completion"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mrd_req && !mv_start && !mv_run)) else $error("idle channel active"); // R1
endmodule

// File: tb/test_lli_chain_loader.sv
`timescale 1ns/1ps
module test_lli_chain_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [2:0]  prog_sel = '0;
  logic [31:0] prog_wdata = '0;
  logic        mrd_req, mrd_ack = 1'b0, mrd_err = 1'b0;
  logic [31:0] mrd_addr, mrd_data = '0;
  logic        mv_start, mv_run, mv_src_inc, mv_dst_inc, mv_done = 1'b0;
  logic [15:0] mv_count, remain_cnt;
  logic [31:0] mv_src, mv_dst, cur_link;
  logic        busy, ev_node, ev_final, ev_err;

  always #2.5 clk = ~clk;

  lli_chain_loader i_lli_chain_loader (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_sel(prog_sel), .prog_wdata(prog_wdata),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data), .mrd_err(mrd_err),
    .mv_start(mv_start), .mv_run(mv_run), .mv_count(mv_count), .mv_src(mv_src), .mv_dst(mv_dst),
    .mv_src_inc(mv_src_inc), .mv_dst_inc(mv_dst_inc), .mv_done(mv_done),
    .cur_link(cur_link), .remain_cnt(remain_cnt), .busy(busy),
    .ev_node(ev_node), .ev_final(ev_final), .ev_err(ev_err)
  );

  typedef struct { logic [15:0] cnt; logic [31:0] src, dst, node; logic si, di; } launch_t;

  logic [31:0] mem [logic [31:0]];
  bit          err_en = 0;
  logic [31:0] err_addr = '0;
  launch_t     lq[$], elq[$];
  logic [31:0] fq[$], efq[$];
  int n_node, n_final, n_err, e_node, e_final;
  int timer = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  // memory responder, mover model and observers
  initial forever begin
    @(negedge clk);
    mrd_ack  = mrd_req;
    mrd_err  = mrd_req && err_en && (mrd_addr == err_addr);
    mrd_data = mem.exists(mrd_addr) ? mem[mrd_addr] : 32'h0;
    if (mrd_req) fq.push_back(mrd_addr);
    if (ev_node) n_node++;
    if (ev_final) n_final++;
    if (ev_err) n_err++;
    mv_done = 1'b0;
    if (mv_start) begin
      lq.push_back('{mv_count, mv_src, mv_dst, cur_link, mv_src_inc, mv_dst_inc});
      timer = 3;
    end else if (mv_run && timer > 0) begin
      timer--;
      if (timer == 0) mv_done = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; prog_we = 1'b0; err_en = 0;
    repeat (3) @(negedge clk);
    lq.delete(); elq.delete(); fq.delete(); efq.delete();
    n_node = 0; n_final = 0; n_err = 0; e_node = 0; e_final = 0; timer = 0;
    rst_n = 1'b1;
  endtask

  task automatic prog(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    prog_we = 1'b1; prog_sel = sel; prog_wdata = data;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic start_direct(input logic [31:0] l, c, s, d, cf);
    prog(3'd0, l); prog(3'd1, c); prog(3'd2, s); prog(3'd3, d); prog(3'd4, cf);
  endtask

  task automatic put_desc(input logic [31:0] a, l, c, s, d, cf);
    mem[a] = l; mem[a+4] = 32'hDEAD0001; mem[a+8] = 32'hDEAD0002; mem[a+12] = 32'hDEAD0003;
    mem[a+16] = c; mem[a+20] = s; mem[a+24] = d; mem[a+28] = cf;
  endtask

  task automatic wait_idle(input int max);
    int n = 0;
    while (busy && n < max) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  // independent model: walk the chain as stored in bench memory
  task automatic model_walk(input logic [31:0] l, c, s, d, cf, input int max_nodes);
    logic [31:0] node = 0;
    for (int k = 0; k < max_nodes; k++) begin
      elq.push_back('{(c > 32'h1FFC) ? 16'h1FFC : c[15:0], s, d, node, cf[31], cf[30]});
      if (cf[1]) e_node++;
      if (!l[1]) begin e_final++; return; end
      node = l & ~32'h1F;
      for (int w = 0; w < 8; w++) efq.push_back(node + 4*w);
      l = mem[node]; c = mem[node+16]; s = mem[node+20]; d = mem[node+24]; cf = mem[node+28];
    end
  endtask

  task automatic compare_launches(input string req, input int n);
    chk({req, " launch count"}, lq.size(), n);
    for (int k = 0; k < n && k < lq.size() && k < elq.size(); k++) begin
      chk({req, " count"}, lq[k].cnt, elq[k].cnt);
      chk({req, " src"}, lq[k].src, elq[k].src);
      chk({req, " dst"}, lq[k].dst, elq[k].dst);
      chk({req, " node addr R9"}, lq[k].node, elq[k].node);
      chk({req, " incs"}, {lq[k].si, lq[k].di}, {elq[k].si, elq[k].di});
    end
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 cur_link", cur_link, 0);
    chk("R1 remain", remain_cnt, 0);
    chk("R1 strobes", {mrd_req, mv_start, ev_node, ev_final, ev_err}, 0);

    // R2 direct single node, R4 end on zero link
    start_direct(32'h0, 32'h40, 32'h8000, 32'h9000, 32'h8000_0001);
    chk("R2 busy rises", busy, 1);
    chk("R8 remain shows count", remain_cnt, 16'h40);
    model_walk(32'h0, 32'h40, 32'h8000, 32'h9000, 32'h8000_0001, 4);
    wait_idle(100);
    compare_launches("R2", 1);
    chk("R4 final once", n_final, 1);
    chk("R6 no node event", n_node, 0);
    chk("R3 no fetch", fq.size(), 0);
    chk("R8 remain idle", remain_cnt, 0);

    // R3/R4/R6 two-node chain with untidy low link bits
    do_reset();
    put_desc(32'h1000, 32'h1033, 32'h20, 32'hA000, 32'hB000, 32'hC000_0001);
    put_desc(32'h1020, 32'h0, 32'h30, 32'hA100, 32'hB100, 32'h4000_0003);
    start_direct(32'h1002, 32'h10, 32'h7000, 32'h7100, 32'hC000_0003);
    model_walk(32'h1002, 32'h10, 32'h7000, 32'h7100, 32'hC000_0003, 8);
    wait_idle(300);
    compare_launches("R3 chain", 3);
    chk("R3 fetch words", fq.size(), efq.size());
    for (int k = 0; k < fq.size() && k < efq.size(); k++) chk("R3 fetch order", fq[k], efq[k]);
    chk("R6 node events", n_node, e_node);
    chk("R4 final chain", n_final, 1);
    chk("R4 busy cleared", busy, 0);

    // R4 nonzero link without chain bit ends the chain
    do_reset();
    put_desc(32'h1040, 32'h0, 32'h5, 32'h1, 32'h2, 32'h1);
    start_direct(32'h1040, 32'h8, 32'h100, 32'h200, 32'h1);
    wait_idle(100);
    chk("R4 no chain bit final", n_final, 1);
    chk("R4 no chain bit no fetch", fq.size(), 0);

    // R8 clamp
    do_reset();
    start_direct(32'h0, 32'h3000, 32'h0, 32'h0, 32'h1);
    chk("R8 remain clamped", remain_cnt, 16'h1FFC);
    wait_idle(100);
    chk("R8 mover count clamped", lq.size() > 0 ? lq[0].cnt : 16'hFFFF, 16'h1FFC);

    // R7 node fetched paused, R11 ignored writes while busy
    do_reset();
    put_desc(32'h1100, 32'h0, 32'h55, 32'hC000, 32'hD000, 32'h8000_0002);
    start_direct(32'h1102, 32'h8, 32'h10, 32'h20, 32'h1);
    repeat (40) @(negedge clk);
    chk("R7 held busy", busy, 1);
    chk("R7 no launch while disabled", lq.size(), 1);
    chk("R7 single fetch", fq.size(), 8);
    chk("R7 run low", mv_run, 0);
    prog(3'd1, 32'h777);
    prog(3'd2, 32'h9999);
    chk("R11 count write ignored", remain_cnt, 16'h55);
    prog(3'd4, 32'h1);
    chk("R7 resumed launch", lq.size(), 2);
    prog(3'd4, 32'h0);
    repeat (20) @(negedge clk);
    chk("R7 mid-node pause holds", {busy, n_final[0]}, 2'b10);
    prog(3'd4, 32'h1);
    wait_idle(100);
    chk("R7 no relaunch", lq.size(), 2);
    chk("R11 src write ignored", lq.size() > 1 ? lq[1].src : 0, 32'hC000);
    chk("R7 no refetch", fq.size(), 8);
    chk("R11 cfg bits kept", n_node, 1);
    chk("R7 final after resume", n_final, 1);

    // R5 cyclic ring
    do_reset();
    put_desc(32'h2000, 32'h2022, 32'h11, 32'h1, 32'h2, 32'h0000_0003);
    put_desc(32'h2020, 32'h2002, 32'h22, 32'h3, 32'h4, 32'h0000_0001);
    start_direct(32'h2002, 32'h4, 32'h0, 32'h0, 32'h1);
    model_walk(32'h2002, 32'h4, 32'h0, 32'h0, 32'h1, 5);
    repeat (150) @(negedge clk);
    chk("R5 never final", n_final, 0);
    chk("R5 still busy", busy, 1);
    chk("R5 many launches", lq.size() >= 5, 1);
    for (int k = 0; k < 5 && k < lq.size(); k++) chk("R5 ring node R9", lq[k].node, elq[k].node);

    // R10 read error aborts
    do_reset();
    put_desc(32'h3000, 32'h0, 32'h9, 32'h1, 32'h2, 32'h1);
    err_addr = 32'h3010; err_en = 1;
    start_direct(32'h3002, 32'h4, 32'h0, 32'h0, 32'h1);
    wait_idle(100);
    chk("R10 error event", n_err, 1);
    chk("R10 busy cleared", busy, 0);
    chk("R10 no final", n_final, 0);
    chk("R10 no further launch", lq.size(), 1);
    chk("R10 reads stopped", fq.size(), 5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1-timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule